// File: doc/BRIEF.md
# Packet-Gated Elastic FIFO

This block moves packets of data words from one clock domain to another when both clocks run at the same nominal rate but come from separate oscillators. The writer pushes a packet one word per write-clock cycle with no gaps. It may idle only between packets. Each stored word carries a start marker and an end marker alongside its data.

A read-side state machine drains the storage on its own and presents each word once on `rd_valid`. It has three states. RD_IDLE waits for any stored word. RD_WAIT_FILL holds off the packet. RD_STREAM reads one word per read-clock cycle. The state machine moves as follows:
- RD_IDLE to RD_WAIT_FILL when the storage is not empty.
- RD_WAIT_FILL to RD_STREAM once at least `START_FILL` words are visible, or once the single word at the head is itself an end-marked word.
- RD_STREAM back to RD_IDLE right after it reads an end-marked word.

Pointers cross the clock boundary as Gray codes through flop chains. The read-side word count is taken from the synchronised write pointer, so it can only under-report. The read side also drives empty and almost-empty flags from that count, and a sticky underflow flag. The write side drives a full flag and a sticky overflow flag.

Top module: `pkt_elastic_fifo`

## Requirements
- R1: After both resets, `rd_empty`=1, `rd_almost_empty`=1, `rd_valid`=0, `wr_full`=0, `wr_overflow`=0 and `rd_underflow`=0.
- R2: Every accepted word appears exactly once on the read side, in write order, with its data, `rd_sop` and `rd_eop` equal to the values written. A word is presented when `rd_valid`=1.
- R3: A packet whose head word has no end marker is not started while fewer than `START_FILL` words (default 2) are held. In particular, a lone first word written into an empty FIFO stays stored and is not presented.
- R4: A word written with both start and end markers set is a one-word packet. It is presented without waiting for a second word.
- R5: Once the first word of a packet is presented, each following word of that packet is presented on consecutive read-clock cycles, up to and including the end-marked word. This holds as long as the writer kept to its no-gap rule.
- R6: `rd_almost_empty` is 1 whenever the read-side count is at most `AE_LEVEL` (default 1). This includes the case where the count reaches one by a write into an empty FIFO and the case where it falls to one by reads.
- R7: `rd_empty` is already 1 in the same cycle that the last stored word is presented on `rd_valid`.
- R8: When `wr_full`=1, a write is dropped, the storage is unchanged and `wr_overflow` is set. `wr_overflow` stays set until the write-side reset.
- R9: When the read side is in RD_STREAM and finds the storage empty before the end-marked word has been read, `rd_underflow` is set. It stays set until the read-side reset.
- R10: Each side has its own synchronous active-low reset. Asserting both resets returns the pointers and all flags to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_en | input | 1 | Push one word this cycle |
| wr_sop | input | 1 | Word is the first of a packet |
| wr_eop | input | 1 | Word is the last of a packet |
| wr_data | input | DATA_W | Word payload |
| wr_full | output | 1 | Storage holds DEPTH words as seen from the write side |
| wr_overflow | output | 1 | Sticky: a write arrived while full |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_valid | output | 1 | A word is presented this cycle |
| rd_sop | output | 1 | Start marker of the presented word |
| rd_eop | output | 1 | End marker of the presented word |
| rd_data | output | DATA_W | Payload of the presented word |
| rd_empty | output | 1 | Read-side count is zero |
| rd_almost_empty | output | 1 | Read-side count is at most AE_LEVEL |
| rd_underflow | output | 1 | Sticky: storage ran dry inside a packet |

## Verification
The bench builds the block with its default parameters: 8-bit data, a depth of 16, a start fill of two words, an almost-empty level of one and two synchroniser stages. The depth of 16 lets the bench reach the full boundary with one 16-word packet while the read clock is held stopped, and then show that the extra writes never come out. The fill level of two and the almost-empty level of one make the one-word holding point visible at the ports, both when it is reached by a write into an empty FIFO and when it is reached by draining. A deliberate gap inside a packet brings the underflow path within reach.

// File: rtl/pef_pkg.sv
package pef_pkg;

    typedef enum logic [1:0] {
        RD_IDLE      = 2'd0,
        RD_WAIT_FILL = 2'd1,
        RD_STREAM    = 2'd2
    } rd_state_t;

endpackage

// File: rtl/pef_mem.sv
module pef_mem #(
    parameter int WORD_W = 10,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/pef_gray_sync.sv
module pef_gray_sync #(
    parameter int PW     = 5,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);

    logic [PW-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain[0] <= '0;
        end else begin
            chain[0] <= gray_in;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[s] <= '0;
            end else begin
                chain[s] <= chain[s-1];
            end
        end
    end

    always_comb begin
        bin_out[PW-1] = chain[STAGES-1][PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ chain[STAGES-1][i];
        end
    end

endmodule

// File: rtl/pef_wr_ctrl.sv
module pef_wr_ctrl #(
    parameter int DEPTH  = 16,
    parameter int STAGES = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray,
    output logic          mem_we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          full,
    output logic          overflow
);

    localparam logic [PW-1:0] PTR_ONE   = PW'(1);
    localparam logic [PW-1:0] PTR_DEPTH = PW'(DEPTH);

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] rbin_seen;

    pef_gray_sync #(.PW(PW), .STAGES(STAGES)) u_rsync (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .gray_in (rgray),
        .bin_out (rbin_seen)
    );

    assign full     = (wbin - rbin_seen) == PTR_DEPTH;
    assign mem_we   = wr_en && !full;
    assign waddr    = wbin[AW-1:0];
    assign wbin_nxt = mem_we ? (wbin + PTR_ONE) : wbin;

    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            overflow <= 1'b0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
            if (wr_en && full) begin
                overflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pef_rd_ctrl.sv
module pef_rd_ctrl
    import pef_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int STAGES     = 2,
    parameter int WORD_W     = 10,
    parameter int START_FILL = 2,
    parameter int AE_LEVEL   = 1,
    localparam int AW        = $clog2(DEPTH),
    localparam int PW        = AW + 1
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic [PW-1:0]     wgray,
    input  logic [WORD_W-1:0] head_word,
    output logic [AW-1:0]     raddr,
    output logic [PW-1:0]     rgray,
    output logic [PW-1:0]     count,
    output logic              empty,
    output logic              almost_empty,
    output logic              underflow,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);

    localparam logic [PW-1:0] PTR_ONE  = PW'(1);
    localparam logic [PW-1:0] FILL_LIM = PW'(START_FILL);
    localparam logic [PW-1:0] AE_LIM   = PW'(AE_LEVEL);
    localparam int            EOP_BIT  = WORD_W - 2;

    rd_state_t     state;
    rd_state_t     state_nxt;
    logic [PW-1:0] rbin;
    logic [PW-1:0] wbin_seen;
    logic          head_eop;
    logic          start_ok;
    logic          fire;
    logic          dry_in_pkt;

    pef_gray_sync #(.PW(PW), .STAGES(STAGES)) u_wsync (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .gray_in (wgray),
        .bin_out (wbin_seen)
    );

    assign count        = wbin_seen - rbin;
    assign empty        = count == '0;
    assign almost_empty = count <= AE_LIM;
    assign raddr        = rbin[AW-1:0];
    assign head_eop     = head_word[EOP_BIT];
    assign start_ok     = (count >= FILL_LIM) || (!empty && head_eop);

    // state register
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            state <= RD_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            RD_IDLE: begin
                if (!empty) begin
                    state_nxt = RD_WAIT_FILL;
                end
            end
            RD_WAIT_FILL: begin
                if (start_ok) begin
                    state_nxt = RD_STREAM;
                end
            end
            RD_STREAM: begin
                if (!empty && head_eop) begin
                    state_nxt = RD_IDLE;
                end
            end
            default: state_nxt = RD_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        fire       = 1'b0;
        dry_in_pkt = 1'b0;
        unique case (state)
            RD_IDLE:      ;
            RD_WAIT_FILL: ;
            RD_STREAM: begin
                fire       = !empty;
                dry_in_pkt = empty;
            end
            default: ;
        endcase
    end

    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin      <= '0;
            rgray     <= '0;
            underflow <= 1'b0;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                rbin     <= rbin + PTR_ONE;
                rgray    <= (rbin + PTR_ONE) ^ ((rbin + PTR_ONE) >> 1);
                out_word <= head_word;
            end
            if (dry_in_pkt) begin
                underflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pkt_elastic_fifo.sv
module pkt_elastic_fifo #(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 16,
    parameter int START_FILL  = 2,
    parameter int AE_LEVEL    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic              rd_valid,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_almost_empty,
    output logic              rd_underflow
);

    localparam int AW     = $clog2(DEPTH);
    localparam int PW     = AW + 1;
    localparam int WORD_W = DATA_W + 2;

    logic              mem_we;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic [PW-1:0]     w_gray;
    logic [PW-1:0]     r_gray;
    logic [PW-1:0]     r_count;
    logic [WORD_W-1:0] head_word;
    logic [WORD_W-1:0] out_word;

    pef_wr_ctrl #(.DEPTH(DEPTH), .STAGES(SYNC_STAGES)) u_wr (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .rgray    (r_gray),
        .mem_we   (mem_we),
        .waddr    (waddr),
        .wgray    (w_gray),
        .full     (wr_full),
        .overflow (wr_overflow)
    );

    pef_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (waddr),
        .wdata  ({wr_sop, wr_eop, wr_data}),
        .raddr  (raddr),
        .rdata  (head_word)
    );

    pef_rd_ctrl #(
        .DEPTH      (DEPTH),
        .STAGES     (SYNC_STAGES),
        .WORD_W     (WORD_W),
        .START_FILL (START_FILL),
        .AE_LEVEL   (AE_LEVEL)
    ) u_rd (
        .rd_clk       (rd_clk),
        .rd_rst_n     (rd_rst_n),
        .wgray        (w_gray),
        .head_word    (head_word),
        .raddr        (raddr),
        .rgray        (r_gray),
        .count        (r_count),
        .empty        (rd_empty),
        .almost_empty (rd_almost_empty),
        .underflow    (rd_underflow),
        .out_valid    (rd_valid),
        .out_word     (out_word)
    );

    assign rd_sop  = out_word[WORD_W-1];
    assign rd_eop  = out_word[WORD_W-2];
    assign rd_data = out_word[DATA_W-1:0];

endmodule

// File: rtl/pef_checker.sv
module pef_checker #(
    parameter int PW         = 5,
    parameter int START_FILL = 2
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          wr_en,
    input logic          wr_full,
    input logic          wr_overflow,
    input logic [PW-1:0] w_gray,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          rd_valid,
    input logic          rd_sop,
    input logic          rd_eop,
    input logic          rd_empty,
    input logic          rd_underflow,
    input logic [PW-1:0] r_count
);

    assert_full_drops_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_full && wr_en |=> $stable(w_gray));

    assert_overflow_sticky_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_overflow |=> wr_overflow);

    assert_underflow_sticky_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_underflow |=> rd_underflow);

    assert_start_gated_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid && rd_sop && !rd_eop |-> $past(r_count) >= PW'(START_FILL));

    assert_stream_unbroken_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid && !rd_eop |=> rd_valid || rd_underflow);

    assert_present_only_stored_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid |-> !$past(rd_empty));

endmodule

bind pkt_elastic_fifo pef_checker #(.PW(PW), .START_FILL(START_FILL)) u_chk (
    .wr_clk       (wr_clk),
    .wr_rst_n     (wr_rst_n),
    .wr_en        (wr_en),
    .wr_full      (wr_full),
    .wr_overflow  (wr_overflow),
    .w_gray       (w_gray),
    .rd_clk       (rd_clk),
    .rd_rst_n     (rd_rst_n),
    .rd_valid     (rd_valid),
    .rd_sop       (rd_sop),
    .rd_eop       (rd_eop),
    .rd_empty     (rd_empty),
    .rd_underflow (rd_underflow),
    .r_count      (r_count)
);

// File: tb/pkt_elastic_fifo_tb_top.sv
`timescale 1ns/1ps
module pkt_elastic_fifo_tb_top;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;

    logic              wr_clk;
    logic              wr_rst_n;
    logic              wr_en;
    logic              wr_sop;
    logic              wr_eop;
    logic [DATA_W-1:0] wr_data;
    logic              wr_full;
    logic              wr_overflow;
    logic              rd_clk;
    logic              rd_rst_n;
    logic              rd_valid;
    logic              rd_sop;
    logic              rd_eop;
    logic [DATA_W-1:0] rd_data;
    logic              rd_empty;
    logic              rd_almost_empty;
    logic              rd_underflow;

    int   checks   = 0;
    int   failures = 0;
    int   out_cnt  = 0;
    logic [DATA_W+1:0] exp_q [$];
    bit   in_pkt      = 0;
    bit   allow_gap   = 0;
    bit   chk_last_mt = 0;
    bit   rd_run      = 1;

    pkt_elastic_fifo #(
        .DATA_W      (DATA_W),
        .DEPTH       (DEPTH),
        .START_FILL  (2),
        .AE_LEVEL    (1),
        .SYNC_STAGES (2)
    ) dut_i (
        .wr_clk          (wr_clk),
        .wr_rst_n        (wr_rst_n),
        .wr_en           (wr_en),
        .wr_sop          (wr_sop),
        .wr_eop          (wr_eop),
        .wr_data         (wr_data),
        .wr_full         (wr_full),
        .wr_overflow     (wr_overflow),
        .rd_clk          (rd_clk),
        .rd_rst_n        (rd_rst_n),
        .rd_valid        (rd_valid),
        .rd_sop          (rd_sop),
        .rd_eop          (rd_eop),
        .rd_data         (rd_data),
        .rd_empty        (rd_empty),
        .rd_almost_empty (rd_almost_empty),
        .rd_underflow    (rd_underflow)
    );

    initial begin
        wr_clk = 1'b0;
        forever #10 wr_clk = ~wr_clk;
    end

    initial begin
        rd_clk = 1'b0;
        #7;
        forever begin
            #10;
            if (rd_run) rd_clk = ~rd_clk;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard compare and stream continuity
    always @(negedge rd_clk) begin
        if (!rd_rst_n) begin
            in_pkt = 0;
        end else if (rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R2", "word with empty scoreboard", int'({rd_sop, rd_eop, rd_data}), -1);
            end else begin
                chk("R2", "presented word", int'({rd_sop, rd_eop, rd_data}), int'(exp_q.pop_front()));
            end
            out_cnt++;
            if (chk_last_mt && rd_eop) chk("R7", "empty with last word", int'(rd_empty), 1);
            in_pkt = !rd_eop;
        end else if (in_pkt && !allow_gap) begin
            chk("R5", "gap inside packet", 0, 1);
        end
    end

    task automatic put(input bit s, input bit e, input logic [DATA_W-1:0] d, input bit keep);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_sop  = s;
        wr_eop  = e;
        wr_data = d;
        if (keep) exp_q.push_back({s, e, d});
    endtask

    task automatic idle_w();
        @(negedge wr_clk);
        wr_en  = 1'b0;
        wr_sop = 1'b0;
        wr_eop = 1'b0;
    endtask

    task automatic send(input int len, input int base);
        for (int i = 0; i < len; i++) begin
            put(i == 0, i == len - 1, DATA_W'(base + i), 1'b1);
        end
        idle_w();
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge wr_clk);
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge wr_clk);
        wcyc(6);
        chk(req, "scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge wr_clk);
        failures++;
        $display("FAIL watchdog all actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        int base;
        wr_en    = 1'b0;
        wr_sop   = 1'b0;
        wr_eop   = 1'b0;
        wr_data  = '0;
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        wcyc(4);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        wcyc(3);

        // R1: reset state
        chk("R1", "rd_empty", int'(rd_empty), 1);
        chk("R1", "rd_almost_empty", int'(rd_almost_empty), 1);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        chk("R1", "wr_full", int'(wr_full), 0);
        chk("R1", "wr_overflow", int'(wr_overflow), 0);
        chk("R1", "rd_underflow", int'(rd_underflow), 0);

        // R3 / R6: one word into an empty FIFO is held, almost-empty on fill
        put(1'b1, 1'b0, 8'h10, 1'b1);
        idle_w();
        wcyc(12);
        chk("R3", "lone first word held", out_cnt, 0);
        chk("R6", "almost empty at one word while filling", int'(rd_almost_empty), 1);
        chk("R6", "not empty at one word", int'(rd_empty), 0);
        put(1'b0, 1'b0, 8'h11, 1'b1);
        put(1'b0, 1'b1, 8'h12, 1'b1);
        idle_w();
        drain("R2");
        chk("R5", "three-word packet delivered", out_cnt, 3);

        // R6: count falls to one by draining
        base = out_cnt;
        for (int i = 0; i < 3; i++) put(i == 0, i == 2, 8'h20 + 8'(i), 1'b1);
        put(1'b1, 1'b0, 8'h30, 1'b1);
        idle_w();
        wcyc(20);
        chk("R3", "next packet head held after drain", out_cnt, base + 3);
        chk("R6", "almost empty at one word after draining", int'(rd_almost_empty), 1);
        chk("R6", "not empty after draining to one", int'(rd_empty), 0);
        put(1'b0, 1'b0, 8'h31, 1'b1);
        put(1'b0, 1'b1, 8'h32, 1'b1);
        idle_w();
        drain("R2");
        chk("R2", "both packets delivered", out_cnt, base + 6);

        // R4 / R7: single-word packet
        base = out_cnt;
        chk_last_mt = 1;
        put(1'b1, 1'b1, 8'h40, 1'b1);
        idle_w();
        drain("R4");
        chk_last_mt = 0;
        chk("R4", "one-word packet released", out_cnt, base + 1);
        chk("R7", "empty after last word", int'(rd_empty), 1);
        chk("R9", "no underflow on clean traffic", int'(rd_underflow), 0);

        // R8: fill to full with the read clock stopped
        base = out_cnt;
        rd_run = 0;
        wcyc(3);
        send(DEPTH, 8'h50);
        put(1'b1, 1'b1, 8'h70, 1'b0);
        put(1'b1, 1'b1, 8'h71, 1'b0);
        idle_w();
        wcyc(2);
        chk("R8", "wr_full at depth", int'(wr_full), 1);
        chk("R8", "wr_overflow after write when full", int'(wr_overflow), 1);
        rd_run = 1;
        drain("R8");
        chk("R8", "only accepted words delivered", out_cnt, base + DEPTH);
        chk("R8", "wr_full clears after drain", int'(wr_full), 0);
        chk("R8", "wr_overflow sticky", int'(wr_overflow), 1);

        // R9: writer gap inside a packet causes underflow
        allow_gap = 1;
        for (int i = 0; i < 3; i++) put(i == 0, 1'b0, 8'h80 + 8'(i), 1'b1);
        idle_w();
        wcyc(8);
        put(1'b0, 1'b0, 8'h83, 1'b1);
        put(1'b0, 1'b1, 8'h84, 1'b1);
        idle_w();
        drain("R9");
        allow_gap = 0;
        chk("R9", "underflow set", int'(rd_underflow), 1);
        wcyc(4);
        chk("R9", "underflow sticky", int'(rd_underflow), 1);

        // R10: per-domain resets clear everything
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        wcyc(4);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        wcyc(4);
        chk("R10", "wr_overflow cleared", int'(wr_overflow), 0);
        chk("R10", "rd_underflow cleared", int'(rd_underflow), 0);
        chk("R10", "rd_empty after reset", int'(rd_empty), 1);
        chk("R10", "wr_full after reset", int'(wr_full), 0);

        // R2: normal traffic after reset
        base = out_cnt;
        send(5, 8'hA0);
        send(2, 8'hB0);
        drain("R2");
        chk("R2", "traffic after reset", out_cnt, base + 7);
        chk("R9", "no underflow after reset traffic", int'(rd_underflow), 0);

        summary();
        $finish;
    end

endmodule